// File: doc/BRIEF.md
# Status Flag Update Unit

This block holds the carry, zero, negative and overflow bits of a small 8-bit processor and decides when and from where each bit is reloaded. The sequencer presents its flag controls during the opcode fetch of the following instruction. In that cycle the unit takes new values from the ALU result, carry out and overflow output, or from a status byte pulled off the stack. A bit that is not selected keeps its value, and in every other cycle all four bits hold.

The carry flag has only one source, the ALU carry out. Pull-status, clear-carry and set-carry are arranged upstream so that the wanted value arrives on that carry output. A pulled byte is shifted right by one through the ALU, so its bit 0 becomes the carry.

The test-and-set-bits and test-and-reset-bits instructions need the zero flag to be computed as accumulator AND memory operand. That test runs on the next opcode fetch, after the modified byte has already been written back. To make it possible, the unit drives the load enable of the external memory operand register. When the sequencer marks the operand read of such an instruction, further operand loads are blocked until the fetch cycle that consumes the value has ended.

Top module: `status_flag_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four flags become 0 and the operand guard is cleared, so that `m_load_en` follows `m_load_req`.
- R2: The flags change only at the edge that ends a cycle with `fetch_cyc` high. In any other cycle all four flags hold, whatever the control and data inputs are.
- R3: On a fetch cycle with `c_load` high, `flag_c` takes `alu_cout`. On a fetch cycle with `c_load` low, `flag_c` holds.
- R4: On a fetch cycle with `nz_sel` = 1 (ALU), `flag_z` becomes 1 exactly when `alu_res` is zero, and `flag_n` takes `alu_res[7]`.
- R5: On a fetch cycle with `nz_sel` = 2 (pull), `flag_z` takes `pull_byte[1]` and `flag_n` takes `pull_byte[7]`.
- R6: On a fetch cycle with `nz_sel` = 3 (bit test), `flag_z` becomes 1 exactly when `acc & mopnd` is zero, and `flag_n` holds.
- R7: On a fetch cycle with `nz_sel` = 0 (keep), `flag_z` and `flag_n` hold.
- R8: On a fetch cycle, `v_sel` = 1 loads `flag_v` from `alu_ovf`, `v_sel` = 2 loads it from `pull_byte[6]`, and `v_sel` = 0 or 3 holds it.
- R9: After any cycle in which `bit_tst_rd` is high, `m_load_en` stays low up to and including the next cycle with `fetch_cyc` high. Outside such a window, `m_load_en` equals `m_load_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_cyc | input | 1 | Current cycle is an opcode fetch, so flag commits are allowed |
| c_load | input | 1 | Load carry from the ALU carry out |
| nz_sel | input | 2 | Zero/negative source: 0 keep, 1 ALU, 2 pull, 3 bit test |
| v_sel | input | 2 | Overflow source: 0 keep, 1 ALU, 2 pull, 3 keep |
| alu_res | input | 8 | ALU result byte |
| alu_cout | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU signed overflow |
| pull_byte | input | 8 | Status byte read from the stack |
| acc | input | 8 | Accumulator value |
| mopnd | input | 8 | Memory operand register value |
| m_load_req | input | 1 | Sequencer request to load the operand register |
| bit_tst_rd | input | 1 | Operand read of a test-and-set or test-and-reset bits instruction |
| m_load_en | output | 1 | Load enable for the operand register |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
A flag that is loaded from the wrong source, or in a cycle other than a fetch, shows up on the flag outputs one clock after the offending edge. Because the flags then hold, the wrong value stays visible until a later fetch cycle happens to overwrite it. A guard that clears too early or sets too late shows up on `m_load_en` in the same cycle, as a load enable that is high during the write or the fetch of a bit-test instruction. A guard that is stuck set shows up as a load request that gets dropped after the fetch. The reference model tracks each flag and the guard per cycle, so any such divergence is reported at the first cycle in which it can be seen.

// File: rtl/sfu_pkg.sv
// Shared types for the status flag update unit.
// Assumes the 2-bit select encodings that the sequencer drives.
package sfu_pkg;
    typedef enum logic [1:0] {
        NZ_KEEP      = 2'd0,
        NZ_FROM_ALU  = 2'd1,
        NZ_FROM_PULL = 2'd2,
        NZ_BIT_TEST  = 2'd3
    } nz_sel_e;

    typedef enum logic [1:0] {
        V_KEEP      = 2'd0,
        V_FROM_ALU  = 2'd1,
        V_FROM_PULL = 2'd2,
        V_RSVD      = 2'd3
    } v_sel_e;
endpackage

// File: rtl/sfu_flag_cell.sv
// One status bit register. Reloads through a feedback multiplexer
// (next = load ? din : q) instead of a flop clock enable.
// Assumes a synchronous active-low reset that clears the bit.
module sfu_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    output logic q
);
    // Purpose: hold or reload the bit, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= load ? din : q;
    end
endmodule

// File: rtl/sfu_zero_detect.sv
// Flags an all-zero vector of parameter width using an OR chain.
// Assumes W >= 1.
module sfu_zero_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic         is_zero
);
    logic [W:0] any_set;

    assign any_set[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_or
            assign any_set[g+1] = any_set[g] | vec[g];
        end
    endgenerate

    assign is_zero = ~any_set[W];
endmodule

// File: rtl/sfu_nz_path.sv
// Zero and negative flag path. On a fetch cycle it loads from the ALU
// result, from the pulled status byte, or from the bit test
// (Z = (acc & mopnd) == 0 with N held). Otherwise both bits hold.
// Assumes acc and mopnd are still valid during the fetch cycle.
module sfu_nz_path #(
    parameter int DW    = 8,
    parameter int Z_BIT = 1,
    parameter int N_BIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_cyc,
    input  sfu_pkg::nz_sel_e   nz_sel,
    input  logic [DW-1:0]      alu_res,
    input  logic [DW-1:0]      pull_byte,
    input  logic [DW-1:0]      acc,
    input  logic [DW-1:0]      mopnd,
    output logic               flag_z,
    output logic               flag_n
);
    import sfu_pkg::*;

    localparam logic [DW-1:0] ONE_HOT = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] USED    = (ONE_HOT << Z_BIT) | (ONE_HOT << N_BIT);

    logic          alu_zero;
    logic          test_zero;
    logic [DW-1:0] masked;
    logic          z_ld, z_din, n_ld, n_din;
    logic          unused_nz_pull;

    assign masked         = acc & mopnd;
    assign unused_nz_pull = ^(pull_byte & ~USED);

    sfu_zero_detect #(.W(DW)) u_alu_zd  (.vec(alu_res), .is_zero(alu_zero));
    sfu_zero_detect #(.W(DW)) u_test_zd (.vec(masked),  .is_zero(test_zero));

    // Purpose: pick the load strobes and new values for Z and N.
    always_comb begin
        z_ld  = 1'b0;
        z_din = flag_z;
        n_ld  = 1'b0;
        n_din = flag_n;
        if (fetch_cyc) begin
            case (nz_sel)
                NZ_FROM_ALU: begin
                    z_ld = 1'b1; z_din = alu_zero;
                    n_ld = 1'b1; n_din = alu_res[DW-1];
                end
                NZ_FROM_PULL: begin
                    z_ld = 1'b1; z_din = pull_byte[Z_BIT];
                    n_ld = 1'b1; n_din = pull_byte[N_BIT];
                end
                NZ_BIT_TEST: begin
                    z_ld = 1'b1; z_din = test_zero;
                end
                default: begin
                    z_ld = 1'b0;
                    n_ld = 1'b0;
                end
            endcase
        end
    end

    sfu_flag_cell u_z (.clk(clk), .rst_n(rst_n), .load(z_ld), .din(z_din), .q(flag_z));
    sfu_flag_cell u_n (.clk(clk), .rst_n(rst_n), .load(n_ld), .din(n_din), .q(flag_n));

    AST_NZ_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && nz_sel == NZ_FROM_ALU |=> flag_z == ($past(alu_res) == '0) && flag_n == $past(alu_res[DW-1])); // R4
    AST_NZ_FROM_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && nz_sel == NZ_FROM_PULL |=> flag_z == $past(pull_byte[Z_BIT]) && flag_n == $past(pull_byte[N_BIT])); // R5
    AST_BIT_TEST_Z: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && nz_sel == NZ_BIT_TEST |=> flag_z == ($past(acc & mopnd) == '0) && $stable(flag_n)); // R6
    AST_NZ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && nz_sel == NZ_KEEP |=> $stable(flag_z) && $stable(flag_n)); // R7
endmodule

// File: rtl/sfu_cv_path.sv
// Carry and overflow flag path. Carry loads only from the ALU carry out;
// overflow loads from the ALU overflow or from the pulled status byte.
// Assumes clear/set/pull of carry arrive through the ALU carry out.
module sfu_cv_path #(
    parameter int DW    = 8,
    parameter int V_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_cyc,
    input  logic               c_load,
    input  sfu_pkg::v_sel_e    v_sel,
    input  logic               alu_cout,
    input  logic               alu_ovf,
    input  logic [DW-1:0]      pull_byte,
    output logic               flag_c,
    output logic               flag_v
);
    import sfu_pkg::*;

    localparam logic [DW-1:0] ONE_HOT = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] USED    = ONE_HOT << V_BIT;

    logic c_ld, v_ld, v_din;
    logic unused_cv_pull;

    assign unused_cv_pull = ^(pull_byte & ~USED);

    // Purpose: carry loads on a fetch cycle when requested.
    always_comb c_ld = fetch_cyc & c_load;

    // Purpose: choose the overflow source for a fetch cycle.
    always_comb begin
        v_ld  = 1'b0;
        v_din = flag_v;
        if (fetch_cyc) begin
            case (v_sel)
                V_FROM_ALU:  begin v_ld = 1'b1; v_din = alu_ovf; end
                V_FROM_PULL: begin v_ld = 1'b1; v_din = pull_byte[V_BIT]; end
                default:     v_ld = 1'b0;
            endcase
        end
    end

    sfu_flag_cell u_c (.clk(clk), .rst_n(rst_n), .load(c_ld), .din(alu_cout), .q(flag_c));
    sfu_flag_cell u_v (.clk(clk), .rst_n(rst_n), .load(v_ld), .din(v_din),    .q(flag_v));

    AST_C_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && c_load |=> flag_c == $past(alu_cout)); // R3
    AST_C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && !c_load |=> $stable(flag_c)); // R3
    AST_V_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && v_sel == V_FROM_ALU |=> flag_v == $past(alu_ovf)); // R8
    AST_V_FROM_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && v_sel == V_FROM_PULL |=> flag_v == $past(pull_byte[V_BIT])); // R8
    AST_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && (v_sel == V_KEEP || v_sel == V_RSVD) |=> $stable(flag_v)); // R8
endmodule

// File: rtl/sfu_mguard.sv
// Operand guard. After the operand read of a bit test instruction it blocks
// operand register loads through the write cycle and the next fetch,
// so that A AND M can still be formed on that fetch.
// Assumes bit_tst_rd is high for one cycle per such instruction.
module sfu_mguard (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_cyc,
    input  logic bit_tst_rd,
    input  logic m_load_req,
    output logic m_load_en
);
    logic guard;

    // Purpose: set on the operand read, release after the fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) guard <= 1'b0;
        else        guard <= bit_tst_rd | (guard & ~fetch_cyc);
    end

    // Purpose: pass the sequencer load request unless guarded.
    always_comb m_load_en = m_load_req & ~guard;

    AST_GUARD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tst_rd |=> !m_load_en); // R9
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !m_load_en && m_load_req && !fetch_cyc |=> !m_load_en); // R9
    AST_GUARD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc && !bit_tst_rd |=> m_load_en == m_load_req); // R9
endmodule

// File: rtl/status_flag_unit.sv
// Status flag update unit: carry, zero, negative and overflow bits,
// committed only on opcode fetch cycles, plus the load enable of the
// memory operand register used by bit test instructions.
// Assumes the sequencer holds its flag controls valid during the fetch.
module status_flag_unit #(
    parameter int DW    = 8,
    parameter int Z_BIT = 1,
    parameter int V_BIT = 6,
    parameter int N_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_cyc,
    input  logic          c_load,
    input  logic [1:0]    nz_sel,
    input  logic [1:0]    v_sel,
    input  logic [DW-1:0] alu_res,
    input  logic          alu_cout,
    input  logic          alu_ovf,
    input  logic [DW-1:0] pull_byte,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mopnd,
    input  logic          m_load_req,
    input  logic          bit_tst_rd,
    output logic          m_load_en,
    output logic          flag_c,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_v
);
    import sfu_pkg::*;

    nz_sel_e nz_sel_t;
    v_sel_e  v_sel_t;

    assign nz_sel_t = nz_sel_e'(nz_sel);
    assign v_sel_t  = v_sel_e'(v_sel);

    sfu_nz_path #(.DW(DW), .Z_BIT(Z_BIT), .N_BIT(N_BIT)) u_nz (
        .clk(clk), .rst_n(rst_n), .fetch_cyc(fetch_cyc), .nz_sel(nz_sel_t),
        .alu_res(alu_res), .pull_byte(pull_byte), .acc(acc), .mopnd(mopnd),
        .flag_z(flag_z), .flag_n(flag_n)
    );

    sfu_cv_path #(.DW(DW), .V_BIT(V_BIT)) u_cv (
        .clk(clk), .rst_n(rst_n), .fetch_cyc(fetch_cyc), .c_load(c_load),
        .v_sel(v_sel_t), .alu_cout(alu_cout), .alu_ovf(alu_ovf),
        .pull_byte(pull_byte), .flag_c(flag_c), .flag_v(flag_v)
    );

    sfu_mguard u_guard (
        .clk(clk), .rst_n(rst_n), .fetch_cyc(fetch_cyc), .bit_tst_rd(bit_tst_rd),
        .m_load_req(m_load_req), .m_load_en(m_load_en)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !flag_c && !flag_z && !flag_n && !flag_v); // R1
    AST_RESET_GUARD: assert property (@(posedge clk)
        !rst_n |=> m_load_en == m_load_req); // R1
    AST_HOLD_OFF_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_cyc |=> $stable({flag_c, flag_z, flag_n, flag_v})); // R2
endmodule

// File: tb/status_flag_unit_bench.sv
`timescale 1ns/1ps
module status_flag_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n, fetch_cyc, c_load, alu_cout, alu_ovf, m_load_req, bit_tst_rd;
    logic [1:0] nz_sel, v_sel;
    logic [7:0] alu_res, pull_byte, acc, mopnd;
    logic       m_load_en, flag_c, flag_z, flag_n, flag_v;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state and the requirement behind each value
    bit    have_state = 1'b0;
    bit    e_c, e_z, e_n, e_v, e_g;
    string w_c, w_z, w_n, w_v;

    always #2.5 clk = ~clk;

    status_flag_unit u_status_flag_unit (
        .clk(clk), .rst_n(rst_n), .fetch_cyc(fetch_cyc), .c_load(c_load),
        .nz_sel(nz_sel), .v_sel(v_sel), .alu_res(alu_res), .alu_cout(alu_cout),
        .alu_ovf(alu_ovf), .pull_byte(pull_byte), .acc(acc), .mopnd(mopnd),
        .m_load_req(m_load_req), .bit_tst_rd(bit_tst_rd), .m_load_en(m_load_en),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // one clock: check the state, drive the inputs, check the enable, advance the model
    task automatic cyc(input bit r, input bit f, input bit cl, input bit [1:0] nzs,
                       input bit [1:0] vs, input bit [7:0] ar, input bit co, input bit ov,
                       input bit [7:0] pb, input bit [7:0] ac, input bit [7:0] mo,
                       input bit mreq, input bit btr);
        @(negedge clk);
        if (have_state) begin
            chk(w_c, "flag_c", flag_c, e_c);
            chk(w_z, "flag_z", flag_z, e_z);
            chk(w_n, "flag_n", flag_n, e_n);
            chk(w_v, "flag_v", flag_v, e_v);
        end
        rst_n = r; fetch_cyc = f; c_load = cl; nz_sel = nzs; v_sel = vs;
        alu_res = ar; alu_cout = co; alu_ovf = ov; pull_byte = pb;
        acc = ac; mopnd = mo; m_load_req = mreq; bit_tst_rd = btr;
        #1;
        if (have_state)
            chk(e_g ? "R9" : "R1/R9", "m_load_en", m_load_en, mreq & ~e_g);
        if (!r) begin
            e_c = 0; e_z = 0; e_n = 0; e_v = 0; e_g = 0;
            w_c = "R1"; w_z = "R1"; w_n = "R1"; w_v = "R1";
            have_state = 1'b1;
        end else if (have_state) begin
            e_g = btr | (e_g & ~f);
            if (!f) begin
                w_c = "R2"; w_z = "R2"; w_n = "R2"; w_v = "R2";
            end else begin
                w_c = "R3";
                if (cl) e_c = co;
                case (nzs)
                    2'd1: begin e_z = (ar == 8'h00); e_n = ar[7]; w_z = "R4"; w_n = "R4"; end
                    2'd2: begin e_z = pb[1]; e_n = pb[7]; w_z = "R5"; w_n = "R5"; end
                    2'd3: begin e_z = ((ac & mo) == 8'h00); w_z = "R6"; w_n = "R6"; end
                    default: begin w_z = "R7"; w_n = "R7"; end
                endcase
                w_v = "R8";
                if (vs == 2'd1) e_v = ov;
                else if (vs == 2'd2) e_v = pb[6];
            end
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        rst_n = 0; fetch_cyc = 0; c_load = 0; nz_sel = 0; v_sel = 0;
        alu_res = 0; alu_cout = 0; alu_ovf = 0; pull_byte = 0;
        acc = 0; mopnd = 0; m_load_req = 0; bit_tst_rd = 0;
        // R1 reset, then its state seen on the next cycle
        cyc(0, 1, 1, 2'd2, 2'd2, 8'h80, 1, 1, 8'hFF, 8'hFF, 8'hFF, 1, 1);
        cyc(0, 0, 0, 2'd0, 2'd0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00, 1, 0);
        // R2 controls outside a fetch cycle are ignored
        cyc(1, 0, 1, 2'd2, 2'd2, 8'h80, 1, 1, 8'hFF, 8'h00, 8'h00, 1, 0);
        // R4 zero result, R3 carry set, R8 overflow from ALU
        cyc(1, 1, 1, 2'd1, 2'd1, 8'h00, 1, 1, 8'h00, 8'h00, 8'h00, 1, 0);
        // R4 negative result
        cyc(1, 1, 0, 2'd1, 2'd0, 8'h9C, 0, 0, 8'h00, 8'h00, 8'h00, 0, 0);
        // R5 pull: Z=bit1, N=bit7, V=bit6, carry via ALU
        cyc(1, 1, 1, 2'd2, 2'd2, 8'h01, 0, 0, 8'h42, 8'h00, 8'h00, 0, 0);
        cyc(1, 1, 1, 2'd2, 2'd2, 8'h01, 1, 0, 8'h81, 8'h00, 8'h00, 0, 0);
        // R9 bit test sequence: read, write, fetch with R6 zero test
        cyc(1, 0, 0, 2'd0, 2'd0, 8'h00, 0, 0, 8'h00, 8'hF0, 8'h0F, 1, 1);
        cyc(1, 0, 0, 2'd0, 2'd0, 8'hFF, 0, 0, 8'h00, 8'hF0, 8'h0F, 1, 0);
        cyc(1, 1, 0, 2'd3, 2'd3, 8'h80, 1, 1, 8'hFF, 8'hF0, 8'h0F, 1, 0);
        cyc(1, 0, 0, 2'd0, 2'd0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00, 1, 0);
        // R6 non-zero overlap clears Z, N held
        cyc(1, 1, 0, 2'd3, 2'd0, 8'h00, 0, 0, 8'h00, 8'h18, 8'h10, 1, 0);
        // R7 keep, R8 reserved select holds
        cyc(1, 1, 0, 2'd0, 2'd3, 8'h00, 1, 0, 8'hFF, 8'h00, 8'h00, 1, 0);
        cyc(1, 0, 0, 2'd0, 2'd0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00, 0, 0);
        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] a = 8'($urandom);
            bit [7:0] m = 8'($urandom);
            cyc(($urandom % 64) != 0, ($urandom % 3) == 0, 1'($urandom), 2'($urandom),
                2'($urandom), (($urandom % 4) == 0) ? 8'h00 : 8'($urandom),
                1'($urandom), 1'($urandom), 8'($urandom),
                a, (($urandom % 3) == 0) ? ~a : m, 1'($urandom), ($urandom % 8) == 0);
        end
        cyc(1, 0, 0, 2'd0, 2'd0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00, 0, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            finish_run();
        end
    end
endmodule